// File: doc/BRIEF.md
# Pixel Hit Latch and Single-Channel Readout Selector

This block is the digital layer behind a pixel matrix of `N_COL` columns by `N_ROW` rows (24 by 64 by default, 1536 channels). Every channel holds a hit flag that is set by a pulse from its discriminator and cleared by a shared clear input. The hit flag also feeds a per-channel shift chain of `ACT_DEPTH` stages (24 by default). This chain runs on the main clock. It exists mainly to create switching activity, and it shows the hit again a fixed number of cycles later.

A serial selection register has one bit per channel. It runs on its own serial clock and is meant to hold a single 1, the token. Each channel gates its hit flag, and its chain tail, with its selection bit through a NAND. The NAND outputs of all channels are wire-ANDed onto two shared active-low buses. The bus therefore reports only the selected channel. If the register holds no 1 or more than one 1, both buses are forced to their idle high level and a fault flag is raised.

Channel index `k = col*N_ROW + row` is the bit position of that channel in the selection register.

Top module: `pix_hit_readout`

## Requirements
- R1: After reset is asserted (`rst_n` low), `rd_bus_n` and `act_bus_n` read 1, `sel_fault` reads 1 (the register is empty) and `sel_dout` reads 0.
- R2: A channel samples `disc_in[k]` high on a rising `clk` edge and sets its hit flag. The flag stays set after the pulse ends, until it is cleared.
- R3: `hit_clr` high at a rising `clk` edge, with no discriminator pulse on the same edge, clears the hit flag of every channel.
- R4: When `disc_in[k]` and `hit_clr` are both high on the same edge, channel k's hit flag is set: the set wins.
- R5: The chain tail of a channel equals its hit flag delayed by exactly `ACT_DEPTH` rising `clk` edges. Take E as the edge that sets the hit. The tail is 0 after edge E+`ACT_DEPTH`-1 and 1 after edge E+`ACT_DEPTH`.
- R6: On each rising `sel_clk` edge, `sel_din` enters bit 0 and every bit moves up one position. Bit k selects channel k = col*`N_ROW`+row. `sel_dout` is the highest bit. After `N_CH` shifts, the bit shifted in at step i (counting from 0) sits at position `N_CH`-1-i.
- R7: With exactly one selection bit set, `rd_bus_n` is the inverse of the selected channel's hit flag, and `act_bus_n` is the inverse of its chain tail.
- R8: Channels that are not selected have no effect on either bus.
- R9: With zero or more than one selection bit set, `sel_fault` is 1 and both buses read 1. With exactly one bit set, `sel_fault` is 0.
- R10: `hit_clr` and discriminator pulses leave the selection register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for the hit flags and activity chains |
| rst_n | input | 1 | Asynchronous active-low reset for all state |
| disc_in | input | N_CH | Discriminator pulse of each channel |
| hit_clr | input | 1 | Shared clear of all hit flags |
| sel_clk | input | 1 | Serial clock of the selection register |
| sel_din | input | 1 | Serial data into bit 0 of the selection register |
| sel_dout | output | 1 | Highest bit of the selection register |
| rd_bus_n | output | 1 | Active-low hit of the selected channel |
| act_bus_n | output | 1 | Active-low chain tail of the selected channel |
| sel_fault | output | 1 | Selection register does not hold exactly one 1 |

## Verification
A wrong hit flag appears on `rd_bus_n` directly after the offending `clk` edge, but only while that channel is selected. The bench therefore places the token first and then drives the channel. A chain with one stage too many or too few shifts the fall of `act_bus_n` by one edge. The bench counts edges from the setting edge to catch this. A misplaced token shows either as a missing response or as a `sel_fault` change right after the last serial shift. A token that is lost or doubled sets `sel_fault`.

// File: rtl/pix_pkg.sv
package pix_pkg;
  // Linear channel position inside the selection register.
  function automatic int unsigned chan_index(input int unsigned col,
                                             input int unsigned row,
                                             input int unsigned n_row);
    return col * n_row + row;
  endfunction

  // True only when exactly one token bit is present.
  function automatic logic token_valid(input int unsigned ones);
    return ones == 1;
  endfunction
endpackage

// File: rtl/pix_channel.sv
module pix_channel #(
  parameter int unsigned ACT_DEPTH = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disc,
  input  logic clr,
  input  logic sel,
  output logic hit_q,
  output logic gate_hit_n,
  output logic gate_act_n
);
  logic [ACT_DEPTH-1:0] act_chain;
  logic                 act_tail;

  // hit flag: set dominates clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hit_q <= 1'b0;
    else if (disc) hit_q <= 1'b1;
    else if (clr)  hit_q <= 1'b0;
  end

  // activity chain fed by the hit flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_chain <= '0;
    else        act_chain <= {act_chain[ACT_DEPTH-2:0], hit_q};
  end

  assign act_tail   = act_chain[ACT_DEPTH-1];
  assign gate_hit_n = ~(sel & hit_q);
  assign gate_act_n = ~(sel & act_tail);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disc |=> hit_q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !disc) |=> !hit_q);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && disc) |=> hit_q);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !disc) |=> $stable(hit_q));
  p_chain_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> act_chain[0] == $past(hit_q));
endmodule

// File: rtl/pix_sel_chain.sv
module pix_sel_chain #(
  parameter int unsigned N_CH = 1536
) (
  input  logic            sel_clk,
  input  logic            rst_n,
  input  logic            sel_din,
  output logic [N_CH-1:0] sel_bits,
  output logic            sel_dout
);
  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) sel_bits <= '0;
    else        sel_bits <= {sel_bits[N_CH-2:0], sel_din};
  end

  assign sel_dout = sel_bits[N_CH-1];

  p_shift_in_r6: assert property (@(posedge sel_clk) disable iff (!rst_n)
    1'b1 |=> sel_bits[0] == $past(sel_din));
  p_shift_out_r6: assert property (@(posedge sel_clk) disable iff (!rst_n)
    1'b1 |=> sel_dout == $past(sel_bits[N_CH-2]));
endmodule

// File: rtl/pix_bus_merge.sv
module pix_bus_merge #(
  parameter int unsigned N_CH = 1536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] sel_bits,
  input  logic [N_CH-1:0] gate_hit_n,
  input  logic [N_CH-1:0] gate_act_n,
  output logic            rd_bus_n,
  output logic            act_bus_n,
  output logic            sel_fault
);
  import pix_pkg::*;

  logic wired_hit_n;
  logic wired_act_n;

  assign wired_hit_n = &gate_hit_n;
  assign wired_act_n = &gate_act_n;
  assign sel_fault   = !token_valid($countones(sel_bits));

  // idle level (high) whenever the token is missing or doubled
  assign rd_bus_n  = sel_fault ? 1'b1 : wired_hit_n;
  assign act_bus_n = sel_fault ? 1'b1 : wired_act_n;

  p_idle_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fault |-> (rd_bus_n && act_bus_n));
  p_fault_matches_token_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel_bits) |-> !sel_fault);
  p_unselected_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bits == '0) |-> rd_bus_n);
endmodule

// File: rtl/pix_hit_readout.sv
module pix_hit_readout #(
  parameter int unsigned N_COL     = 24,
  parameter int unsigned N_ROW     = 64,
  parameter int unsigned ACT_DEPTH = 24,
  localparam int unsigned N_CH     = N_COL * N_ROW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] disc_in,
  input  logic            hit_clr,
  input  logic            sel_clk,
  input  logic            sel_din,
  output logic            sel_dout,
  output logic            rd_bus_n,
  output logic            act_bus_n,
  output logic            sel_fault
);
  import pix_pkg::*;

  logic [N_CH-1:0] sel_bits;
  logic [N_CH-1:0] hit_vec;
  logic [N_CH-1:0] gate_hit_n;
  logic [N_CH-1:0] gate_act_n;

  pix_sel_chain #(.N_CH(N_CH)) u_sel (
    .sel_clk (sel_clk),
    .rst_n   (rst_n),
    .sel_din (sel_din),
    .sel_bits(sel_bits),
    .sel_dout(sel_dout)
  );

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    for (genvar r = 0; r < N_ROW; r++) begin : g_row
      localparam int unsigned K = chan_index(c, r, N_ROW);
      pix_channel #(.ACT_DEPTH(ACT_DEPTH)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .disc      (disc_in[K]),
        .clr       (hit_clr),
        .sel       (sel_bits[K]),
        .hit_q     (hit_vec[K]),
        .gate_hit_n(gate_hit_n[K]),
        .gate_act_n(gate_act_n[K])
      );
    end
  end

  pix_bus_merge #(.N_CH(N_CH)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_bits  (sel_bits),
    .gate_hit_n(gate_hit_n),
    .gate_act_n(gate_act_n),
    .rd_bus_n  (rd_bus_n),
    .act_bus_n (act_bus_n),
    .sel_fault (sel_fault)
  );

  // the hit flags change nothing in the selection register
  p_token_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr && !sel_clk && $stable(sel_clk)) |=> ($stable(sel_bits) || $rose(sel_clk)));
  p_bus_follows_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_fault && (hit_vec & sel_bits) != '0) |-> !rd_bus_n);
endmodule

// File: tb/pix_hit_readout_tb.sv
module pix_hit_readout_tb;
  localparam int NC = 24;
  localparam int NR = 64;
  localparam int DEPTH = 24;
  localparam int NCH = NC * NR;

  logic clk = 0, rst_n = 0, hit_clr = 0, sel_clk = 0, sel_din = 0;
  logic [NCH-1:0] disc_in = '0;
  logic sel_dout, rd_bus_n, act_bus_n, sel_fault;
  int total = 0, bad = 0;
  bit done = 0;

  pix_hit_readout #(.N_COL(NC), .N_ROW(NR), .ACT_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .hit_clr(hit_clr),
    .sel_clk(sel_clk), .sel_din(sel_din), .sel_dout(sel_dout),
    .rd_bus_n(rd_bus_n), .act_bus_n(act_bus_n), .sel_fault(sel_fault));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int idx(input int col, input int row);
    return row + NR * col;
  endfunction

  task automatic shift_bit(input logic b);
    sel_din = b; #3 sel_clk = 1; #3 sel_clk = 0;
  endtask

  // full-length load: bit shifted at step i lands at NCH-1-i
  task automatic load_sel(input int a, input int b);
    for (int i = 0; i < NCH; i++)
      shift_bit((NCH - 1 - i == a) || (NCH - 1 - i == b));
  endtask

  task automatic hit_pulse(input int k, input logic with_clr);
    @(negedge clk); disc_in[k] = 1; hit_clr = with_clr;
    @(posedge clk); #1;
    @(negedge clk); disc_in[k] = 0; hit_clr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); hit_clr = 1;
    @(negedge clk); hit_clr = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; #20;
    chk("R1 rd_bus_n", rd_bus_n, 1);
    chk("R1 act_bus_n", act_bus_n, 1);
    chk("R1 sel_fault", sel_fault, 1);
    chk("R1 sel_dout", sel_dout, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_latch();
    int k = idx(3, 7);
    load_sel(k, -1);
    chk("R9 single token no fault", sel_fault, 0);
    chk("R7 idle before hit", rd_bus_n, 1);
    hit_pulse(k, 0);
    chk("R2/R7 hit shown", rd_bus_n, 0);
    repeat (5) @(negedge clk);
    chk("R2 hit held", rd_bus_n, 0);
    clear_all();
    chk("R3 cleared", rd_bus_n, 1);
  endtask

  task automatic t_chain();
    int k = idx(3, 7);
    repeat (DEPTH + 2) @(negedge clk);
    @(negedge clk); disc_in[k] = 1;
    @(posedge clk); #1;           // edge E
    disc_in[k] = 0;
    repeat (DEPTH - 1) @(posedge clk);
    #1 chk("R5 tail not yet at E+DEPTH-1", act_bus_n, 1);
    @(posedge clk); #1;
    chk("R5/R7 tail at E+DEPTH", act_bus_n, 0);
    clear_all();
    repeat (DEPTH + 1) @(negedge clk);
    chk("R5 tail drained", act_bus_n, 1);
  endtask

  task automatic t_priority();
    int k = idx(3, 7);
    hit_pulse(k, 1);
    chk("R4 set wins over clear", rd_bus_n, 0);
    clear_all();
  endtask

  task automatic t_other();
    hit_pulse(idx(15, 40), 0);
    repeat (DEPTH + 2) @(negedge clk);
    chk("R8 other channel hit", rd_bus_n, 1);
    chk("R8 other channel tail", act_bus_n, 1);
  endtask

  task automatic t_fault();
    int a = idx(3, 7), b = idx(15, 40);
    hit_pulse(a, 0);
    load_sel(a, b);
    #1 chk("R9 two tokens fault", sel_fault, 1);
    chk("R9 two tokens bus idle", rd_bus_n, 1);
    load_sel(-1, -1);
    #1 chk("R9 no token fault", sel_fault, 1);
    chk("R9 no token bus idle", rd_bus_n, 1);
    load_sel(b, -1);
    #1 chk("R6/R7 token moved to other channel", rd_bus_n, 0);
    clear_all();
    chk("R3 cleared all", rd_bus_n, 1);
  endtask

  task automatic t_shift_end();
    int k = idx(NC - 1, NR - 1);
    load_sel(k, -1);
    #1 chk("R6 top bit reaches sel_dout", sel_dout, 1);
    hit_pulse(k, 0);
    chk("R6 index col*rows+row", rd_bus_n, 0);
    clear_all();
    clear_all();
    chk("R10 token kept after clears", sel_fault, 0);
    chk("R10 sel_dout kept", sel_dout, 1);
    shift_bit(0);
    #1 chk("R6 token shifted out", sel_fault, 1);
    chk("R6 sel_dout after shift", sel_dout, 0);
  endtask

  initial begin
    t_reset();
    t_latch();
    t_chain();
    t_priority();
    t_other();
    t_fault();
    t_shift_end();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule